// File: doc/BRIEF.md
# Issue Queue Wakeup Scoreboard

This block keeps renamed instructions that are waiting for their source operands, in a fixed number of slots. It also keeps one ready flag for each physical register. An accepted instruction takes the lowest free slot. Each of its two sources is either marked ready at once or left waiting on its register tag. A completion port broadcasts a finished destination tag. That tag wakes every waiting slot that names it, and all slots are compared in the same cycle.

A slot whose sources are all ready raises a request bit in one of three vectors: integer, floating-point or control. The slot's sequence number is visible next to that request. A squash port carries a sequence number. Every live slot that is younger than that number and not yet squashed moves to a fourth request vector, the squashed vector, which the selector drains like any other. Choosing among requests is done outside the block. The selector returns a grant with a slot index, and that grant frees the slot.

Top module: `iq_wakeup_sb`

## Requirements
- R1: After reset all four request vectors are zero, the free count equals the queue depth, `full` is low and every register ready flag is clear.
- R2: An accepted instruction with `ins_dst_vld` set clears the ready flag of its destination tag. This clear wins over a completion of the same tag in the same cycle, so a later consumer of that tag waits.
- R3: When an instruction is accepted, a source flagged ready by the producer of the instruction is ready. A source flagged unready is ready if its register ready flag is already set, and otherwise it waits on its tag. A source tag at or above the register count is ready.
- R4: A completion in the same cycle as an insert makes an unready-flagged source with that tag ready.
- R5: A completion with a tag below the register count sets that register's ready flag. It also marks ready, at the next clock edge, every waiting source in every live slot that names the tag.
- R6: A completion tag at or above the register count changes no flag and wakes no slot.
- R7: A live, unsquashed slot with both sources ready raises exactly one bit, at its slot index, in the vector for its class. The class codes are 0 integer, 1 floating-point and 2 control.
- R8: `full` is high exactly when the free count is zero. An insert while full is not accepted, raises `ins_err` in that cycle and changes no state.
- R9: A squash marks squashed every live, unsquashed slot whose sequence number is greater than the squash number, comparing them as unsigned values. Older slots and slots with an equal number are untouched.
- R10: A squashed slot leaves its class vector and raises its bit in `rdy_sq` until it is granted. A later wakeup does not move it back.
- R11: A grant of a live slot frees it and adds one to the free count at the same edge. A grant together with an accepted insert leaves the count unchanged.
- R12: An insert with class code 3 is not accepted, raises `ins_err` and changes no state.
- R13: An accepted insert takes the lowest-indexed free slot, as seen before that edge, and exposes its sequence number on that slot's field of `ent_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_cls | input | 2 | Class: 0 int, 1 fp, 2 control, 3 invalid |
| ins_seq | input | SEQ_W | Sequence number of the instruction |
| ins_s0_tag | input | TAG_W | Source 0 physical tag |
| ins_s0_rdy | input | 1 | Source 0 already ready per rename |
| ins_s1_tag | input | TAG_W | Source 1 physical tag |
| ins_s1_rdy | input | 1 | Source 1 already ready per rename |
| ins_dst_tag | input | TAG_W | Destination physical tag |
| ins_dst_vld | input | 1 | Instruction writes a destination |
| ins_err | output | 1 | Insert refused (full or invalid class) |
| cmp_valid | input | 1 | Completion broadcast |
| cmp_tag | input | TAG_W | Completed destination tag |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash sequence number |
| grant_valid | input | 1 | Selector grant |
| grant_idx | input | $clog2(DEPTH) | Granted slot index |
| full | output | 1 | No free slot |
| free_cnt | output | $clog2(DEPTH+1) | Number of free slots |
| rdy_int | output | DEPTH | Integer ready requests, one bit per slot |
| rdy_fp | output | DEPTH | Floating-point ready requests |
| rdy_ctl | output | DEPTH | Control ready requests |
| rdy_sq | output | DEPTH | Squashed-drain requests |
| ent_seq | output | DEPTH*SEQ_W | Sequence number of each slot, slot 0 in the low bits |

## Verification
A stale or wrongly cleared register flag shows up one cycle after the insert that consults it: the slot either requests too early in its class vector or never requests until a second completion arrives. A slot with a lost squash mark keeps requesting in its class vector instead of `rdy_sq`, which is visible in the cycle after the squash. A drifting free count shows up in `full` and `ins_err`, at the latest when the queue fills. Each scenario therefore samples the outputs in the cycle directly after the edge that should change them.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_CTL = 2'd2,
        CLS_BAD = 2'd3
    } iq_cls_e;

    localparam int SEQ_CMP_W = 32;

    function automatic logic is_younger(input logic [SEQ_CMP_W-1:0] cand,
                                        input logic [SEQ_CMP_W-1:0] bound);
        return cand > bound;
    endfunction

    function automatic logic cls_ok(input iq_cls_e c);
        return c != CLS_BAD;
    endfunction

endpackage

// File: rtl/iq_regready.sv
module iq_regready
    import iq_pkg::*;
#(
    parameter int NPREG = 64,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [TAG_W-1:0] q0_tag,
    input  logic [TAG_W-1:0] q1_tag,
    output logic             q0_rdy,
    output logic             q1_rdy
);

    logic [NPREG-1:0] flag_q;
    logic [NPREG-1:0] flag_n;

    // A tag that names no register never matches an index, so it is ignored.
    always_comb begin
        flag_n = flag_q;
        for (int i = 0; i < NPREG; i++) begin
            if (set_en && set_tag == TAG_W'(i)) flag_n[i] = 1'b1;
            if (clr_en && clr_tag == TAG_W'(i)) flag_n[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_n;
    end

    function automatic logic lookup(input logic [TAG_W-1:0] t,
                                    input logic [NPREG-1:0] f,
                                    input logic s_en,
                                    input logic [TAG_W-1:0] s_tag);
        logic hit;
        logic inrange;
        hit = 1'b0;
        inrange = 1'b0;
        for (int i = 0; i < NPREG; i++) begin
            if (t == TAG_W'(i)) begin
                inrange = 1'b1;
                hit = f[i];
            end
        end
        if (s_en && s_tag == t) hit = 1'b1;
        return inrange ? hit : 1'b1;
    endfunction

    assign q0_rdy = lookup(q0_tag, flag_q, set_en, set_tag);
    assign q1_rdy = lookup(q1_tag, flag_q, set_en, set_tag);

    for (genvar g = 0; g < NPREG; g++) begin : g_chk
        // R2: a new producer always leaves its register unready
        assert_dst_clear_R2: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_tag == TAG_W'(g)) |=> !flag_q[g]);
        // R5: a completion without a competing clear leaves the flag set
        assert_cmp_sets_R5: assert property (@(posedge clk) disable iff (rst)
            (set_en && set_tag == TAG_W'(g) && !(clr_en && clr_tag == TAG_W'(g)))
            |=> flag_q[g]);
    end

    // R6: a completion beyond the register file changes no flag
    assert_oob_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (set_en && int'(set_tag) >= NPREG && !clr_en) |=> (flag_q == $past(flag_q)));

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] busy,
    output logic [DEPTH-1:0] pick
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!busy[i] && !taken) begin
                pick[i] = 1'b1;
                taken   = 1'b1;
            end
        end
    end

    // R13: at most one slot is chosen, and it is a free one
    always_comb begin
        assert_pick_single_R13: assert ($onehot0(pick));
        assert_pick_free_R13: assert ((pick & busy) == '0);
    end

endmodule

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int TAG_W = 7,
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  iq_cls_e          a_cls,
    input  logic [SEQ_W-1:0] a_seq,
    input  logic [TAG_W-1:0] a_t0,
    input  logic             a_r0,
    input  logic [TAG_W-1:0] a_t1,
    input  logic             a_r1,
    input  logic             wk_en,
    input  logic [TAG_W-1:0] wk_tag,
    input  logic             sq_en,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             grant,
    output logic             live,
    output logic [SEQ_W-1:0] seq,
    output logic             req_int,
    output logic             req_fp,
    output logic             req_ctl,
    output logic             req_sq
);

    typedef struct packed {
        logic             valid;
        logic             sqd;
        iq_cls_e          cls;
        logic [SEQ_W-1:0] seq;
        logic [TAG_W-1:0] t0;
        logic             r0;
        logic [TAG_W-1:0] t1;
        logic             r1;
    } slot_t;

    slot_t q, n;

    always_comb begin
        n = q;
        if (q.valid) begin
            if (wk_en && !q.r0 && q.t0 == wk_tag) n.r0 = 1'b1;
            if (wk_en && !q.r1 && q.t1 == wk_tag) n.r1 = 1'b1;
            if (sq_en && !q.sqd &&
                is_younger(SEQ_CMP_W'(q.seq), SEQ_CMP_W'(sq_seq))) begin
                n.sqd = 1'b1;
                n.r0  = 1'b1;
                n.r1  = 1'b1;
            end
            if (grant) begin
                n.valid = 1'b0;
                n.sqd   = 1'b0;
            end
        end
        if (alloc) begin
            n.valid = 1'b1;
            n.sqd   = 1'b0;
            n.cls   = a_cls;
            n.seq   = a_seq;
            n.t0    = a_t0;
            n.r0    = a_r0;
            n.t1    = a_t1;
            n.r1    = a_r1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    logic both_rdy;
    assign both_rdy = q.valid && !q.sqd && q.r0 && q.r1;
    assign req_int  = both_rdy && q.cls == CLS_INT;
    assign req_fp   = both_rdy && q.cls == CLS_FP;
    assign req_ctl  = both_rdy && q.cls == CLS_CTL;
    assign req_sq   = q.valid && q.sqd;
    assign live     = q.valid;
    assign seq      = q.seq;

    // R7: a slot requests on at most one vector
    assert_one_vector_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_int, req_fp, req_ctl, req_sq}));
    // R9: a younger live slot hit by a squash is squashed next cycle
    assert_squash_marks_R9: assert property (@(posedge clk) disable iff (rst)
        (sq_en && q.valid && !q.sqd && !grant && !alloc && q.seq > sq_seq)
        |=> req_sq);
    // R10: a squashed slot stays on the drain path until granted
    assert_squash_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (req_sq && !grant) |=> (req_sq && !req_int && !req_fp && !req_ctl));
    // R11: a granted slot is free next cycle unless reallocated
    assert_grant_frees_R11: assert property (@(posedge clk) disable iff (rst)
        (grant && q.valid && !alloc) |=> !live);

endmodule

// File: rtl/iq_wakeup_sb.sv
module iq_wakeup_sb
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NPREG = 64,
    parameter int TAG_W = 7,
    parameter int SEQ_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_valid,
    input  logic [1:0]             ins_cls,
    input  logic [SEQ_W-1:0]       ins_seq,
    input  logic [TAG_W-1:0]       ins_s0_tag,
    input  logic                   ins_s0_rdy,
    input  logic [TAG_W-1:0]       ins_s1_tag,
    input  logic                   ins_s1_rdy,
    input  logic [TAG_W-1:0]       ins_dst_tag,
    input  logic                   ins_dst_vld,
    output logic                   ins_err,
    input  logic                   cmp_valid,
    input  logic [TAG_W-1:0]       cmp_tag,
    input  logic                   sq_valid,
    input  logic [SEQ_W-1:0]       sq_seq,
    input  logic                   grant_valid,
    input  logic [IDX_W-1:0]       grant_idx,
    output logic                   full,
    output logic [CNT_W-1:0]       free_cnt,
    output logic [DEPTH-1:0]       rdy_int,
    output logic [DEPTH-1:0]       rdy_fp,
    output logic [DEPTH-1:0]       rdy_ctl,
    output logic [DEPTH-1:0]       rdy_sq,
    output logic [DEPTH*SEQ_W-1:0] ent_seq
);

    iq_cls_e          cls_in;
    logic             accept;
    logic             cmp_act;
    logic [CNT_W-1:0] free_q;
    logic [DEPTH-1:0] live_vec;
    logic [DEPTH-1:0] pick_vec;
    logic [DEPTH-1:0] grant_vec;
    logic             grant_ok;
    logic             sb_r0, sb_r1;

    assign cls_in  = iq_cls_e'(ins_cls);
    assign full    = (free_q == '0);
    assign ins_err = ins_valid && (full || !cls_ok(cls_in));
    assign accept  = ins_valid && !full && cls_ok(cls_in);
    assign cmp_act = cmp_valid && (int'(cmp_tag) < NPREG);

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            grant_vec[i] = grant_valid && grant_idx == IDX_W'(i) && live_vec[i];
    end
    assign grant_ok = |grant_vec;

    always_ff @(posedge clk) begin
        if (rst) free_q <= CNT_W'(DEPTH);
        else     free_q <= free_q - CNT_W'(accept) + CNT_W'(grant_ok);
    end
    assign free_cnt = free_q;

    iq_regready #(.NPREG(NPREG), .TAG_W(TAG_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .set_en (cmp_valid),
        .set_tag(cmp_tag),
        .clr_en (accept && ins_dst_vld),
        .clr_tag(ins_dst_tag),
        .q0_tag (ins_s0_tag),
        .q1_tag (ins_s1_tag),
        .q0_rdy (sb_r0),
        .q1_rdy (sb_r1)
    );

    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .busy(live_vec),
        .pick(pick_vec)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        iq_entry #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .alloc  (accept && pick_vec[g]),
            .a_cls  (cls_in),
            .a_seq  (ins_seq),
            .a_t0   (ins_s0_tag),
            .a_r0   (ins_s0_rdy || sb_r0),
            .a_t1   (ins_s1_tag),
            .a_r1   (ins_s1_rdy || sb_r1),
            .wk_en  (cmp_act),
            .wk_tag (cmp_tag),
            .sq_en  (sq_valid),
            .sq_seq (sq_seq),
            .grant  (grant_vec[g]),
            .live   (live_vec[g]),
            .seq    (ent_seq[g*SEQ_W +: SEQ_W]),
            .req_int(rdy_int[g]),
            .req_fp (rdy_fp[g]),
            .req_ctl(rdy_ctl[g]),
            .req_sq (rdy_sq[g])
        );
    end

    // R8: the count never exceeds the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        int'(free_q) <= DEPTH);
    // R11: free slots and live slots always add up to the depth
    assert_count_match_R11: assert property (@(posedge clk) disable iff (rst)
        int'($countones(live_vec)) + int'(free_q) == DEPTH);
    // R8: a refused insert leaves the count untouched apart from a grant
    assert_full_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && full && !grant_ok) |=> (free_q == '0));
    // R12: an invalid class never takes a slot
    assert_bad_class_R12: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && cls_in == CLS_BAD && !grant_ok) |=> (free_q == $past(free_q)));

endmodule

// File: tb/iq_wakeup_sb_tb_top.sv
`timescale 1ns/1ps
module iq_wakeup_sb_tb_top;

    localparam int DEPTH = 4;
    localparam int NPREG = 32;
    localparam int TAG_W = 6;
    localparam int SEQ_W = 8;
    localparam int IDX_W = 2;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             ins_valid, ins_s0_rdy, ins_s1_rdy, ins_dst_vld, ins_err;
    logic [1:0]       ins_cls;
    logic [SEQ_W-1:0] ins_seq, sq_seq;
    logic [TAG_W-1:0] ins_s0_tag, ins_s1_tag, ins_dst_tag, cmp_tag;
    logic             cmp_valid, sq_valid, grant_valid, full;
    logic [IDX_W-1:0] grant_idx;
    logic [CNT_W-1:0] free_cnt;
    logic [DEPTH-1:0] rdy_int, rdy_fp, rdy_ctl, rdy_sq;
    logic [DEPTH*SEQ_W-1:0] ent_seq;

    iq_wakeup_sb #(.DEPTH(DEPTH), .NPREG(NPREG), .TAG_W(TAG_W), .SEQ_W(SEQ_W)) dut_i (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_cls(ins_cls), .ins_seq(ins_seq),
        .ins_s0_tag(ins_s0_tag), .ins_s0_rdy(ins_s0_rdy),
        .ins_s1_tag(ins_s1_tag), .ins_s1_rdy(ins_s1_rdy),
        .ins_dst_tag(ins_dst_tag), .ins_dst_vld(ins_dst_vld), .ins_err(ins_err),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .full(full), .free_cnt(free_cnt),
        .rdy_int(rdy_int), .rdy_fp(rdy_fp), .rdy_ctl(rdy_ctl), .rdy_sq(rdy_sq),
        .ent_seq(ent_seq)
    );

    typedef struct {
        string       req;
        logic [20:0] exp;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int fails  = 0;

    function automatic logic [20:0] pack_obs(input logic [3:0] i, f, c, s,
                                             input logic [2:0] n,
                                             input logic fl, er);
        return {i, f, c, s, n, fl, er};
    endfunction

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [20:0] act;
            it  = exp_q.pop_front();
            act = pack_obs(rdy_int, rdy_fp, rdy_ctl, rdy_sq, free_cnt, full, ins_err);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual int=%b fp=%b ctl=%b sq=%b free=%0d full=%b err=%b expected int=%b fp=%b ctl=%b sq=%b free=%0d full=%b err=%b",
                         it.req, act[20:17], act[16:13], act[12:9], act[8:5], act[4:2], act[1], act[0],
                         it.exp[20:17], it.exp[16:13], it.exp[12:9], it.exp[8:5], it.exp[4:2], it.exp[1], it.exp[0]);
            end
        end
    end

    task automatic idle();
        ins_valid = 0; ins_cls = 0; ins_seq = 0;
        ins_s0_tag = 0; ins_s0_rdy = 0; ins_s1_tag = 0; ins_s1_rdy = 0;
        ins_dst_tag = 0; ins_dst_vld = 0;
        cmp_valid = 0; cmp_tag = 0; sq_valid = 0; sq_seq = 0;
        grant_valid = 0; grant_idx = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic expect_now(input string req, input logic [3:0] i, f, c, s,
                              input logic [2:0] n, input logic fl, er);
        item_t it;
        it.req = req;
        it.exp = pack_obs(i, f, c, s, n, fl, er);
        exp_q.push_back(it);
        @(negedge clk);
        #0.1;
    endtask

    task automatic put(input logic [1:0] cls, input logic [7:0] seq,
                       input logic [5:0] t0, input logic r0,
                       input logic [5:0] t1, input logic r1,
                       input logic [5:0] dst);
        ins_valid = 1; ins_cls = cls; ins_seq = seq;
        ins_s0_tag = t0; ins_s0_rdy = r0; ins_s1_tag = t1; ins_s1_rdy = r1;
        ins_dst_tag = dst; ins_dst_vld = 1;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        step(); rst = 0;
        expect_now("R1 reset state", 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd4, 0, 0);
        step(); cmp_valid = 1; cmp_tag = 6'd5;
        expect_now("R1 idle after reset", 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd4, 0, 0);
        step(); put(2'd0, 8'd10, 6'd5, 0, 6'd6, 0, 6'd7);
        expect_now("R5 completion alone raises nothing", 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd4, 0, 0);
        step(); cmp_valid = 1; cmp_tag = 6'd6;
        expect_now("R3 flagged source ready, other waits", 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd3, 0, 0);
        step(); cmp_valid = 1; cmp_tag = 6'd9;
        expect_now("R5 wakeup of waiting source", 4'b0001, 4'b0000, 4'b0000, 4'b0000, 3'd3, 0, 0);
        step(); put(2'd1, 8'd11, 6'd1, 1, 6'd2, 1, 6'd9);
        expect_now("R7 integer slot stays on its vector", 4'b0001, 4'b0000, 4'b0000, 4'b0000, 3'd3, 0, 0);
        step(); put(2'd2, 8'd12, 6'd9, 0, 6'd3, 1, 6'd10);
        expect_now("R7 fp slot on fp vector", 4'b0001, 4'b0010, 4'b0000, 4'b0000, 3'd2, 0, 0);
        step(); cmp_valid = 1; cmp_tag = 6'd41;
        expect_now("R2 new producer cleared flag, consumer waits", 4'b0001, 4'b0010, 4'b0000, 4'b0000, 3'd1, 0, 0);
        step();
        expect_now("R6 out-of-range tag wakes nothing", 4'b0001, 4'b0010, 4'b0000, 4'b0000, 3'd1, 0, 0);
        step(); cmp_valid = 1; cmp_tag = 6'd9;
        expect_now("R6 still waiting", 4'b0001, 4'b0010, 4'b0000, 4'b0000, 3'd1, 0, 0);
        step(); put(2'd0, 8'd13, 6'd20, 0, 6'd21, 1, 6'd11);
        expect_now("R5 control slot woken", 4'b0001, 4'b0010, 4'b0100, 4'b0000, 3'd1, 0, 0);
        step(); put(2'd0, 8'd14, 6'd1, 1, 6'd2, 1, 6'd12);
        expect_now("R8 insert while full refused", 4'b0001, 4'b0010, 4'b0100, 4'b0000, 3'd0, 1, 1);
        step(); sq_valid = 1; sq_seq = 8'd11;
        expect_now("R8 refused insert left no trace", 4'b0001, 4'b0010, 4'b0100, 4'b0000, 3'd0, 1, 0);
        step(); cmp_valid = 1; cmp_tag = 6'd20;
        expect_now("R9 younger slots squashed, equal kept", 4'b0001, 4'b0010, 4'b0000, 4'b1100, 3'd0, 1, 0);
        step(); grant_valid = 1; grant_idx = 2'd2;
        expect_now("R10 wakeup ignored for squashed slot", 4'b0001, 4'b0010, 4'b0000, 4'b1100, 3'd0, 1, 0);
        step(); grant_valid = 1; grant_idx = 2'd0;
        put(2'd0, 8'd14, 6'd1, 1, 6'd2, 1, 6'd12);
        expect_now("R11 grant drained squashed slot", 4'b0001, 4'b0010, 4'b0000, 4'b1000, 3'd1, 0, 0);
        step(); put(2'd1, 8'd15, 6'd25, 0, 6'd2, 1, 6'd13);
        cmp_valid = 1; cmp_tag = 6'd25;
        expect_now("R13 grant plus insert, lowest free slot", 4'b0100, 4'b0010, 4'b0000, 4'b1000, 3'd1, 0, 0);
        checks++;
        if (ent_seq[2*SEQ_W +: SEQ_W] !== 8'd14) begin
            fails++;
            $display("FAIL R13 slot 2 sequence: actual %0d expected 14", ent_seq[2*SEQ_W +: SEQ_W]);
        end
        step(); grant_valid = 1; grant_idx = 2'd1;
        expect_now("R4 same-cycle completion readies source", 4'b0100, 4'b0011, 4'b0000, 4'b1000, 3'd0, 1, 0);
        step(); put(2'd3, 8'd16, 6'd1, 1, 6'd2, 1, 6'd14);
        expect_now("R12 invalid class refused", 4'b0100, 4'b0001, 4'b0000, 4'b1000, 3'd1, 0, 1);
        step();
        expect_now("R12 invalid class took no slot", 4'b0100, 4'b0001, 4'b0000, 4'b1000, 3'd1, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule